// File: doc/BRIEF.md
# Condition Register Logic Unit

This block is a purely combinational execution stage that works on a 32-bit condition register. It treats the register as eight 4-bit fields and has a single 2-bit opcode that selects one of four operations. The first combines two register bits through a 4-entry truth table and writes the result to a third bit. The second copies one whole field onto another. The third is a 64-bit integer select that returns one of two operands, chosen by a bit from a separately supplied field. The fourth passes the register through unchanged.

Fields and bits are numbered from the most significant end. Field 0 is the top nibble, and bit number 0 is register bit 31. A surrounding pipeline places the instruction's selector fields on the inputs and takes the updated register, or the selected integer, in the same cycle. All widths and counts are parameters, and their consistency is checked at elaboration.

Top module: `crlu_top`

## Requirements
- R1: Field number f (0..7) occupies register bits 4*(7-f)+3 down to 4*(7-f), and bit number n (0..31) is register bit 31-n.
- R2: The opcode on `op_i` is encoded as follows: 0 is the bit logic operation, 1 is the field copy, 2 is the integer select and 3 is the pass-through.
- R3: For the integer select, the chosen bit is `sel_fld_i[3 - bc_i[1:0]]`. The upper three bits of `bc_i` are ignored. `res_o` equals `a_i` when the chosen bit is 1 and `b_i` when it is 0.
- R4: For the bit logic operation, with x the bit numbered `ba_i` and y the bit numbered `bb_i`, the bit numbered `bt_i` of `cr_o` becomes `tbl_i[{x,y}]`. So mask bit 0 applies when both inputs are 0 and mask bit 3 when both are 1, and the mask 4'b0110 yields x XOR y.
- R5: For the bit logic operation, every bit of `cr_o` other than the bit numbered `bt_i` equals the same bit of `cr_i`.
- R6: For the field copy, field `dst_i` of `cr_o` equals field `src_i` of `cr_i`, and every other field is unchanged. When `dst_i` equals `src_i`, `cr_o` equals `cr_i`.
- R7: For the pass-through and the integer select, `cr_o` equals `cr_i`.
- R8: For every opcode other than the integer select, `res_o` is zero.
- R9: The block holds no state. The outputs follow the inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 2 | Operation code |
| a_i | input | 64 | Integer operand chosen when the select bit is 1 |
| b_i | input | 64 | Integer operand chosen when the select bit is 0 |
| sel_fld_i | input | 4 | Field that supplies the select bit |
| cr_i | input | 32 | Full condition register in |
| ba_i | input | 5 | Bit number of the first logic input |
| bb_i | input | 5 | Bit number of the second logic input |
| bt_i | input | 5 | Bit number of the logic result |
| dst_i | input | 3 | Destination field number for the copy |
| src_i | input | 3 | Source field number for the copy |
| tbl_i | input | 4 | Truth-table mask for the logic operation |
| bc_i | input | 5 | Select-bit index; only the low two bits are used |
| cr_o | output | 32 | Full condition register out |
| res_o | output | 64 | Integer select result |

## Verification
The hardest cases to reach are the logic operations in which the source bits and the target bit overlap, and the copies in which both field numbers are equal. Under uniform random selectors these occur only rarely. The bench therefore forces `ba_i`, `bb_i` and `bt_i` to coincide and sets `dst_i` equal to `src_i` in directed passes. It also sweeps all 16 masks across all four input-bit combinations, and all four select indices with the chosen bit both set and clear. Random rounds, with the upper bits of `bc_i` left noisy, cover the remaining combinations.

// File: rtl/crlu_pkg.sv
package crlu_pkg;
   typedef enum logic [1:0] {
      CRLU_OP_LOGIC = 2'd0,
      CRLU_OP_MOVE  = 2'd1,
      CRLU_OP_SEL   = 2'd2,
      CRLU_OP_PASS  = 2'd3
   } crlu_op_e;
endpackage

// File: rtl/crlu_bitlogic.sv
// Bit logic: two register bits index a truth table, the result lands on a third bit.
module crlu_bitlogic #(
   parameter int CR_W  = 32,
   parameter int BIT_W = $clog2(CR_W)
) (
   input  logic [CR_W-1:0]  cr_i,
   input  logic [BIT_W-1:0] ba_i,
   input  logic [BIT_W-1:0] bb_i,
   input  logic [BIT_W-1:0] bt_i,
   input  logic [3:0]       tbl_i,
   output logic [CR_W-1:0]  cr_o
);
   // Reversed view: index n addresses bit number n (MSB-first).
   logic [CR_W-1:0] cr_rev;
   logic            in_x;
   logic            in_y;
   logic            new_bit;

   for (genvar k = 0; k < CR_W; k++) begin : g_rev
      assign cr_rev[k] = cr_i[CR_W-1-k];
   end

   assign in_x    = cr_rev[ba_i];
   assign in_y    = cr_rev[bb_i];
   assign new_bit = tbl_i[{in_x, in_y}];

   for (genvar k = 0; k < CR_W; k++) begin : g_wr
      assign cr_o[CR_W-1-k] = (bt_i == BIT_W'(k)) ? new_bit : cr_i[CR_W-1-k];
   end
endmodule

// File: rtl/crlu_fieldmove.sv
// Field copy: one field replaces another, all others pass.
module crlu_fieldmove #(
   parameter int FIELD_W    = 4,
   parameter int NUM_FIELDS = 8,
   parameter int FSEL_W     = $clog2(NUM_FIELDS),
   parameter int CR_W       = FIELD_W * NUM_FIELDS
) (
   input  logic [CR_W-1:0]   cr_i,
   input  logic [FSEL_W-1:0] dst_i,
   input  logic [FSEL_W-1:0] src_i,
   output logic [CR_W-1:0]   cr_o
);
   logic [FIELD_W-1:0] fld [NUM_FIELDS];
   logic [FIELD_W-1:0] moved;

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_split
      assign fld[f] = cr_i[(NUM_FIELDS-1-f)*FIELD_W +: FIELD_W];
   end

   assign moved = fld[src_i];

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_join
      assign cr_o[(NUM_FIELDS-1-f)*FIELD_W +: FIELD_W] =
         (dst_i == FSEL_W'(f)) ? moved : fld[f];
   end
endmodule

// File: rtl/crlu_intsel.sv
// Integer select: one bit of a field picks between two operands.
module crlu_intsel #(
   parameter int FIELD_W = 4,
   parameter int DATA_W  = 64,
   parameter int IDX_W   = $clog2(FIELD_W)
) (
   input  logic [FIELD_W-1:0] fld_i,
   input  logic [IDX_W-1:0]   idx_i,
   input  logic [DATA_W-1:0]  a_i,
   input  logic [DATA_W-1:0]  b_i,
   output logic [DATA_W-1:0]  res_o
);
   logic [FIELD_W-1:0] fld_rev;
   logic               pick;

   for (genvar j = 0; j < FIELD_W; j++) begin : g_rev
      assign fld_rev[j] = fld_i[FIELD_W-1-j];
   end

   assign pick  = fld_rev[idx_i];
   assign res_o = pick ? a_i : b_i;
endmodule

// File: rtl/crlu_top.sv
module crlu_top
   import crlu_pkg::*;
#(
   parameter int FIELD_W    = 4,
   parameter int NUM_FIELDS = 8,
   parameter int DATA_W     = 64,
   parameter int BC_W       = 5,
   localparam int CR_W      = FIELD_W * NUM_FIELDS,
   localparam int BIT_W     = $clog2(CR_W),
   localparam int FSEL_W    = $clog2(NUM_FIELDS),
   localparam int IDX_W     = $clog2(FIELD_W)
) (
   input  logic [1:0]         op_i,
   input  logic [DATA_W-1:0]  a_i,
   input  logic [DATA_W-1:0]  b_i,
   input  logic [FIELD_W-1:0] sel_fld_i,
   input  logic [CR_W-1:0]    cr_i,
   input  logic [BIT_W-1:0]   ba_i,
   input  logic [BIT_W-1:0]   bb_i,
   input  logic [BIT_W-1:0]   bt_i,
   input  logic [FSEL_W-1:0]  dst_i,
   input  logic [FSEL_W-1:0]  src_i,
   input  logic [3:0]         tbl_i,
   input  logic [BC_W-1:0]    bc_i,
   output logic [CR_W-1:0]    cr_o,
   output logic [DATA_W-1:0]  res_o
);
   // Elaboration-time parameter checks.
   if (FIELD_W < 2 || (1 << IDX_W) != FIELD_W) begin : g_bad_field
      $error("crlu_top: FIELD_W must be a power of two of at least 2");
   end
   if ((1 << BIT_W) != CR_W) begin : g_bad_cr
      $error("crlu_top: FIELD_W*NUM_FIELDS must be a power of two");
   end
   if (BC_W <= IDX_W) begin : g_bad_bc
      $error("crlu_top: BC_W must exceed the select index width");
   end

   crlu_op_e         op;
   logic [CR_W-1:0]  cr_logic;
   logic [CR_W-1:0]  cr_move;
   logic [DATA_W-1:0] res_sel;
   logic             unused_bc_hi;

   assign op           = crlu_op_e'(op_i);
   assign unused_bc_hi = ^bc_i[BC_W-1:IDX_W];

   crlu_bitlogic #(.CR_W(CR_W), .BIT_W(BIT_W)) u_logic (
      .cr_i  (cr_i),
      .ba_i  (ba_i),
      .bb_i  (bb_i),
      .bt_i  (bt_i),
      .tbl_i (tbl_i),
      .cr_o  (cr_logic)
   );

   crlu_fieldmove #(
      .FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS), .FSEL_W(FSEL_W), .CR_W(CR_W)
   ) u_move (
      .cr_i  (cr_i),
      .dst_i (dst_i),
      .src_i (src_i),
      .cr_o  (cr_move)
   );

   crlu_intsel #(.FIELD_W(FIELD_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_sel (
      .fld_i (sel_fld_i),
      .idx_i (bc_i[IDX_W-1:0]),
      .a_i   (a_i),
      .b_i   (b_i),
      .res_o (res_sel)
   );

   always_comb begin
      cr_o  = cr_i;
      res_o = '0;
      unique case (op)
         CRLU_OP_LOGIC: cr_o  = cr_logic;
         CRLU_OP_MOVE:  cr_o  = cr_move;
         CRLU_OP_SEL:   res_o = res_sel;
         CRLU_OP_PASS:  cr_o  = cr_i;
         default:       cr_o  = cr_i;
      endcase
   end
endmodule

// File: rtl/crlu_top_chk.sv
// Port-level checker, bound to every crlu_top instance.
module crlu_top_chk #(
   parameter int CR_W   = 32,
   parameter int DATA_W = 64,
   parameter int BIT_W  = 5,
   parameter int FSEL_W = 3,
   parameter int FIELD_W = 4
) (
   input logic [1:0]        op_i,
   input logic [DATA_W-1:0] a_i,
   input logic [DATA_W-1:0] b_i,
   input logic [CR_W-1:0]   cr_i,
   input logic [BIT_W-1:0]  ba_i,
   input logic [BIT_W-1:0]  bb_i,
   input logic [BIT_W-1:0]  bt_i,
   input logic [FSEL_W-1:0] dst_i,
   input logic [3:0]        tbl_i,
   input logic [CR_W-1:0]   cr_o,
   input logic [DATA_W-1:0] res_o
);
   function automatic logic [CR_W-1:0] flip(input logic [CR_W-1:0] v);
      logic [CR_W-1:0] r;
      for (int k = 0; k < CR_W; k++) r[k] = v[CR_W-1-k];
      return r;
   endfunction

   function automatic logic [CR_W-1:0] keep_mask(input logic [FSEL_W-1:0] f);
      logic [CR_W-1:0] m;
      m = '1;
      for (int k = 0; k < FIELD_W; k++)
         m[CR_W-1-(int'(f)*FIELD_W)-k] = 1'b0;
      return m;
   endfunction

   logic [CR_W-1:0] in_rev;
   logic [CR_W-1:0] out_rev;
   assign in_rev  = flip(cr_i);
   assign out_rev = flip(cr_o);

   always_comb begin
      if (op_i == 2'd2) begin
         p_sel_operand_r3: assert (res_o == a_i || res_o == b_i)
            else $error("select result is neither operand");
      end
      if (op_i == 2'd0 && tbl_i == 4'b0110) begin
         p_xor_mask_r4: assert (out_rev[bt_i] == (in_rev[ba_i] ^ in_rev[bb_i]))
            else $error("mask 0110 did not give xor");
      end
      if (op_i == 2'd0) begin
         p_single_bit_r5: assert ($countones(cr_o ^ cr_i) <= 1)
            else $error("logic op changed more than one bit");
      end
      if (op_i == 2'd1) begin
         p_move_others_r6: assert (((cr_o ^ cr_i) & keep_mask(dst_i)) == '0)
            else $error("copy touched a non-destination field");
      end
      if (op_i == 2'd2 || op_i == 2'd3) begin
         p_cr_passes_r7: assert (cr_o == cr_i)
            else $error("register changed on pass or select");
      end
      if (op_i != 2'd2) begin
         p_res_zero_r8: assert (res_o == '0)
            else $error("integer result not zero");
      end
   end
endmodule

bind crlu_top crlu_top_chk #(
   .CR_W(CR_W), .DATA_W(DATA_W), .BIT_W(BIT_W), .FSEL_W(FSEL_W), .FIELD_W(FIELD_W)
) u_chk (
   .op_i  (op_i),
   .a_i   (a_i),
   .b_i   (b_i),
   .cr_i  (cr_i),
   .ba_i  (ba_i),
   .bb_i  (bb_i),
   .bt_i  (bt_i),
   .dst_i (dst_i),
   .tbl_i (tbl_i),
   .cr_o  (cr_o),
   .res_o (res_o)
);

// File: tb/crlu_top_bench.sv
`timescale 1ns/1ps
module crlu_top_bench;
   logic        clk = 1'b0;
   always #10 clk = ~clk;

   logic [1:0]  op;
   logic [63:0] a, b;
   logic [3:0]  sfld;
   logic [31:0] cr;
   logic [4:0]  ba, bb, bt;
   logic [2:0]  dst, src;
   logic [3:0]  tbl;
   logic [4:0]  bc;
   logic [31:0] cr_out;
   logic [63:0] res_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   crlu_top u_crlu_top (
      .op_i(op), .a_i(a), .b_i(b), .sel_fld_i(sfld), .cr_i(cr),
      .ba_i(ba), .bb_i(bb), .bt_i(bt), .dst_i(dst), .src_i(src),
      .tbl_i(tbl), .bc_i(bc), .cr_o(cr_out), .res_o(res_out)
   );

   // Reference model written from the requirements.
   function automatic logic get_bit(input logic [31:0] v, input int n);
      return v[31-n];
   endfunction

   function automatic logic [31:0] exp_cr();
      logic [31:0] r;
      logic        x, y;
      r = cr;
      case (op)
         2'd0: begin
            x = get_bit(cr, ba);
            y = get_bit(cr, bb);
            r[31-bt] = tbl[{x, y}];
         end
         2'd1: r[4*(7-dst) +: 4] = cr[4*(7-src) +: 4];
         default: r = cr;
      endcase
      return r;
   endfunction

   function automatic logic [63:0] exp_res();
      if (op != 2'd2) return 64'd0;
      return sfld[3 - bc[1:0]] ? a : b;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (op %0d)", req, act, exp, op);
      end
   endtask

   task automatic settle_and_check(input string req);
      #1;
      chk(req, {32'd0, cr_out}, {32'd0, exp_cr()});
      chk(req, res_out, exp_res());
   endtask

   task automatic randomize_all();
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      sfld = 4'($urandom); cr = $urandom;
      ba = 5'($urandom); bb = 5'($urandom); bt = 5'($urandom);
      dst = 3'($urandom); src = 3'($urandom);
      tbl = 4'($urandom); bc = 5'($urandom);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7041));
      op = 0; a = 0; b = 0; sfld = 0; cr = 0; ba = 0; bb = 0; bt = 0;
      dst = 0; src = 0; tbl = 0; bc = 0;
      @(negedge clk);
      // Idle state with all inputs zero.
      #1; chk("R8 idle", res_out, 64'd0);
      chk("R5 idle", {32'd0, cr_out}, 64'd0);

      // R1 layout: copy field 0 (top nibble) to field 7 (bottom nibble).
      @(negedge clk);
      op = 2'd1; cr = 32'hA000_0000; dst = 3'd7; src = 3'd0;
      #1; chk("R1 field layout", {32'd0, cr_out}, 64'h0000_0000_A000_000A);
      // R1 bit numbering: bit 0 is MSB, copy through table "pass x" (mask 1100).
      op = 2'd0; cr = 32'h8000_0000; ba = 0; bb = 0; bt = 5'd31; tbl = 4'b1100;
      #1; chk("R1 bit numbering", {32'd0, cr_out}, 64'h0000_0000_8000_0001);

      // R4: all 16 masks against all four input pairs.
      for (int m = 0; m < 16; m++) begin
         for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            randomize_all();
            op = 2'd0; tbl = 4'(m);
            cr[31-ba] = p[1]; cr[31-bb] = p[0];
            if (ba == bb) bb = bb + 5'd1;
            cr[31-bb] = p[0];
            settle_and_check("R4 mask sweep");
         end
      end
      // R5: overlapping source and target bits.
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         randomize_all();
         op = 2'd0; bb = ba; bt = ba;
         settle_and_check("R5 overlap");
      end

      // R3: all indices, bit set and clear, noisy upper bc bits.
      for (int ix = 0; ix < 4; ix++) begin
         for (int v = 0; v < 2; v++) begin
            @(negedge clk);
            randomize_all();
            op = 2'd2; bc = {3'($urandom), 2'(ix)};
            sfld[3-ix] = v[0];
            settle_and_check("R3 select index");
            chk("R3 operand", res_out, v[0] ? a : b);
         end
      end

      // R6: copy onto itself.
      for (int f = 0; f < 8; f++) begin
         @(negedge clk);
         randomize_all();
         op = 2'd1; dst = 3'(f); src = 3'(f);
         #1; chk("R6 self copy", {32'd0, cr_out}, {32'd0, cr});
      end

      // R7 pass-through, R2 encodings via random mix, R9 same-cycle response.
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         randomize_all();
         op = 2'($urandom);
         case (op)
            2'd3: settle_and_check("R7 pass");
            2'd2: settle_and_check("R7 select keeps cr");
            2'd1: settle_and_check("R6 random copy");
            default: settle_and_check("R2 random logic");
         endcase
      end

      // R9: change inputs mid-cycle, result visible with no clock edge.
      @(posedge clk); #3;
      randomize_all(); op = 2'd2; bc = 5'd0; sfld = 4'b1000;
      #1; chk("R9 no clock needed", res_out, a);
      sfld = 4'b0000;
      #1; chk("R9 follows input", res_out, b);

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule